// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier Element

This element computes the Montgomery product Z = X·Y·2^-n mod M for long operands. It uses one datapath of fixed width W. Each operand is held in a word-addressed store as e = ceil(n/W) words of W bits, where n is the operand length chosen at start. The element takes one bit of X per outer step. In each step it makes one pass over all the words of Y, M and the running value Z, and writes every word of Z back to the store. One narrow datapath therefore serves any operand length up to the size of the store.

Each pass uses two one-bit carry chains. The first ripples the X-bit-times-Y term and the second ripples the reduce-times-M term. The reduce bit is taken once per pass, at word 0, and is held for the rest of the pass. The divide-by-two is done on the way back to the store: each word written is spliced together from the low bit of the next word and the top W-1 bits of its own word. A mode input turns every addition into a carry-free XOR, so the same hardware multiplies in GF(2^n). The result is left in redundant range below 2M. The element does not normalize it.

Top module: `mont_word_pe`

## Requirements
- R1: After reset, and at any time busy_o is low, busy_o, done_o and z_we_o are all low.
- R2: start_i is sampled only while busy_o is low, and nbits_i must satisfy W < nbits_i <= W·MAX_WORDS. busy_o is high from the following edge up to and including the done_o cycle. done_o is a single-cycle pulse that is high after exactly n·(e+1)+2 rising edges counted from the edge that sampled start_i.
- R3: In integer mode, with M odd, 2^(n-1) < M < 2^n, X < 2^n and Y < M, the final Z held in store words 0..e satisfies Z < 2M and Z·2^n ≡ X·Y (mod M).
- R4: Each outer step i (i = 0..n-1, bit i of X being bit i mod W of X word floor(i/W)) computes Z' = (Z + x_i·Y + r·M)/2, where r is the least significant bit of Z + x_i·Y. Z word k holds bits kW..kW+W-1.
- R5: Each outer step writes store words 0, 1, ..., e exactly once and in ascending order. A run makes n·(e+1) writes in total and never writes an address above e.
- R6: With the GF mode input high at start, all additions are carry-free XOR. M is then a degree-n polynomial with n < e·W, and the result satisfies Z·x^n ≡ X·Y modulo M over GF(2).
- R7: Z is taken as zero during the first outer step. Whatever the store held before the start has no effect on the result.
- R8: Y and M words at index e and above are read as zero, whatever the store holds there.
- R9: A start_i pulse while busy_o is high is ignored, together with the nbits_i and mode values that come with it. The latency and result of the run in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a multiplication (sampled while idle) |
| nbits_i | input | $clog2(W·MAX_WORDS+1) | Operand length n in bits |
| gf_mode_i | input | 1 | 1: GF(2^n) polynomial mode, 0: integer mode |
| x_addr_o | output | $clog2(MAX_WORDS+1) | X word address |
| x_word_i | input | W | X word, one cycle after the address |
| rd_addr_o | output | $clog2(MAX_WORDS+1) | Shared Y/M/Z read address |
| y_word_i | input | W | Y word, one cycle after the address |
| m_word_i | input | W | M word, one cycle after the address |
| z_word_i | input | W | Z word, one cycle after the address |
| z_we_o | output | 1 | Z store write enable |
| z_waddr_o | output | $clog2(MAX_WORDS+1) | Z store write address |
| z_wdata_o | output | W | Z store write data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the smallest legal length, where e = 2. There the write of a word and its next read are closest together, and a design that read a word before writing it back would corrupt the low words of Z. The bench also uses lengths that are exact multiples of W and fills the Y and M locations at and above e with nonzero data. A design that failed to mask those words would add stray multiples of M into the top word. The Z store is preloaded with nonzero data, which catches a design that does not treat Z as zero in the first step. The bench runs a 64-bit operand with all-ones X and Y = M-1, which catches a carry dropped at the top word. Polynomial runs catch a carry that leaks into GF mode. A start pulse in the middle of a run catches a design that reloads its length or mode.

// File: rtl/mont_pe_pkg.sv
package mont_pe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_TAIL,
    ST_FLUSH,
    ST_DONE
  } pe_state_e;
endpackage

// File: rtl/mont_pe_alu.sv
module mont_pe_alu #(
  parameter int W = 16
) (
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] m_i,
  input  logic         x_bit_i,
  input  logic         word0_i,
  input  logic         red_hold_i,
  input  logic         ca_i,
  input  logic         cb_i,
  input  logic         gf_i,
  output logic [W-1:0] z_o,
  output logic         red_o,
  output logic         ca_o,
  output logic         cb_o
);
  logic [W-1:0] y_term, m_term;
  logic [W:0]   sum_a, sum_b;
  logic         ca_in, cb_in, red;

  always_comb begin
    y_term = x_bit_i ? y_i : '0;
    ca_in  = ca_i & ~word0_i & ~gf_i;
    cb_in  = cb_i & ~word0_i & ~gf_i;
    if (gf_i) sum_a = {1'b0, z_i ^ y_term};
    else      sum_a = {1'b0, z_i} + {1'b0, y_term} + (W+1)'(ca_in);
    // reduce bit is fixed at word 0 and held for the rest of the pass
    red    = word0_i ? sum_a[0] : red_hold_i;
    m_term = red ? m_i : '0;
    if (gf_i) sum_b = {1'b0, sum_a[W-1:0] ^ m_term};
    else      sum_b = {1'b0, sum_a[W-1:0]} + {1'b0, m_term} + (W+1)'(cb_in);
  end

  assign z_o   = sum_b[W-1:0];
  assign red_o = red;
  assign ca_o  = sum_a[W];
  assign cb_o  = sum_b[W];
endmodule

// File: rtl/mont_pe_seq.sv
module mont_pe_seq
  import mont_pe_pkg::*;
#(
  parameter int W         = 16,
  parameter int MAX_WORDS = 8,
  parameter int AW        = 4,
  parameter int NBW       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NBW-1:0]  nbits_i,
  input  logic            gf_mode_i,
  output pe_state_e       state_o,
  output logic [AW-1:0]   e_o,
  output logic [AW-1:0]   j_o,
  output logic [NBW-1:0]  i_o,
  output logic            gf_o,
  output logic            issue_o
);
  localparam int LOG_W = $clog2(W);

  pe_state_e      state_q;
  logic [AW-1:0]  e_q, j_q;
  logic [NBW-1:0] n_q, i_q;
  logic           gf_q;
  logic [NBW:0]   n_round;

  assign n_round = {1'b0, nbits_i} + (NBW+1)'(W-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      e_q     <= '0;
      j_q     <= '0;
      n_q     <= '0;
      i_q     <= '0;
      gf_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          e_q     <= AW'(n_round >> LOG_W);
          n_q     <= nbits_i;
          gf_q    <= gf_mode_i;
          j_q     <= '0;
          i_q     <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (j_q == e_q) begin
            j_q <= '0;
            if (i_q == n_q - 1'b1) state_q <= ST_TAIL;
            else                   i_q     <= i_q + 1'b1;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_TAIL:  state_q <= ST_FLUSH;
        ST_FLUSH: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign e_o     = e_q;
  assign j_o     = j_q;
  assign i_o     = i_q;
  assign gf_o    = gf_q;
  assign issue_o = (state_q == ST_RUN);

  // R2: legal operand length at start (e >= 2 keeps write-back ahead of re-read)
  p_legal_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |->
      (nbits_i > NBW'(W) && nbits_i <= NBW'(W*MAX_WORDS)));

  // R9: run configuration holds for the whole run
  p_cfg_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |->
      ($stable(e_q) && $stable(n_q) && $stable(gf_q)));
endmodule

// File: rtl/mont_word_pe.sv
module mont_word_pe
  import mont_pe_pkg::*;
#(
  parameter int W         = 16,
  parameter int MAX_WORDS = 8,
  localparam int AW       = $clog2(MAX_WORDS+1),
  localparam int NBW      = $clog2(W*MAX_WORDS+1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [NBW-1:0] nbits_i,
  input  logic           gf_mode_i,
  output logic [AW-1:0]  x_addr_o,
  input  logic [W-1:0]   x_word_i,
  output logic [AW-1:0]  rd_addr_o,
  input  logic [W-1:0]   y_word_i,
  input  logic [W-1:0]   m_word_i,
  input  logic [W-1:0]   z_word_i,
  output logic           z_we_o,
  output logic [AW-1:0]  z_waddr_o,
  output logic [W-1:0]   z_wdata_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int LOG_W = $clog2(W);

  pe_state_e      state;
  logic [AW-1:0]  e, j;
  logic [NBW-1:0] i;
  logic           gf, issue;

  mont_pe_seq #(.W(W), .MAX_WORDS(MAX_WORDS), .AW(AW), .NBW(NBW)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .nbits_i   (nbits_i),
    .gf_mode_i (gf_mode_i),
    .state_o   (state),
    .e_o       (e),
    .j_o       (j),
    .i_o       (i),
    .gf_o      (gf),
    .issue_o   (issue)
  );

  assign rd_addr_o = j;
  assign x_addr_o  = AW'(i >> LOG_W);

  // read-data stage: word index and bit select delayed by the memory latency
  logic             p_vld, p_first;
  logic [AW-1:0]    p_j;
  logic [LOG_W-1:0] p_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld   <= 1'b0;
      p_first <= 1'b0;
      p_j     <= '0;
      p_bit   <= '0;
    end else begin
      p_vld   <= issue;
      p_first <= (i == '0);
      p_j     <= j;
      p_bit   <= i[LOG_W-1:0];
    end
  end

  logic [W-1:0] y_eff, m_eff, z_eff, z_new, prev_q;
  logic         red_new, ca_new, cb_new, red_q, ca_q, cb_q;

  assign y_eff = (p_j < e) ? y_word_i : '0;
  assign m_eff = (p_j < e) ? m_word_i : '0;
  assign z_eff = p_first ? '0 : z_word_i;

  mont_pe_alu #(.W(W)) i_alu (
    .z_i        (z_eff),
    .y_i        (y_eff),
    .m_i        (m_eff),
    .x_bit_i    (x_word_i[p_bit]),
    .word0_i    (p_j == '0),
    .red_hold_i (red_q),
    .ca_i       (ca_q),
    .cb_i       (cb_q),
    .gf_i       (gf),
    .z_o        (z_new),
    .red_o      (red_new),
    .ca_o       (ca_new),
    .cb_o       (cb_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ca_q   <= 1'b0;
      cb_q   <= 1'b0;
      red_q  <= 1'b0;
      prev_q <= '0;
    end else if (p_vld) begin
      ca_q   <= ca_new;
      cb_q   <= cb_new;
      red_q  <= red_new;
      prev_q <= z_new;
    end
  end

  // shift splice: word k-1 gets the low bit of word k on top
  always_comb begin
    z_we_o    = 1'b0;
    z_waddr_o = '0;
    z_wdata_o = '0;
    if (p_vld && p_j != '0) begin
      z_we_o    = 1'b1;
      z_waddr_o = p_j - 1'b1;
      z_wdata_o = {z_new[0], prev_q[W-1:1]};
    end else if ((p_vld && !p_first) || state == ST_FLUSH) begin
      z_we_o    = 1'b1;
      z_waddr_o = e;
      z_wdata_o = {1'b0, prev_q[W-1:1]};
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!z_we_o && !done_o));

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_reduce_clears_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_vld && p_j == '0) |-> (z_new[0] == 1'b0));

  p_top_carry_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_vld && p_j == e) |-> (!ca_new && !cb_new));

  p_waddr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_we_o |-> (z_waddr_o <= e));

  p_write_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_we_o && $past(z_we_o)) |->
      (z_waddr_o == (($past(z_waddr_o) == e) ? AW'(0) : AW'($past(z_waddr_o) + 1'b1))));
endmodule

// File: tb/test_mont_word_pe.sv
module test_mont_word_pe;
  localparam int W   = 8;
  localparam int MW  = 8;
  localparam int AW  = $clog2(MW+1);
  localparam int NBW = $clog2(W*MW+1);

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [NBW-1:0] nbits_i = '0;
  logic           gf_mode_i = 1'b0;
  logic [AW-1:0]  x_addr_o, rd_addr_o, z_waddr_o;
  logic [W-1:0]   x_word_i, y_word_i, m_word_i, z_word_i, z_wdata_o;
  logic           z_we_o, busy_o, done_o;

  always #4 clk_i = ~clk_i;

  mont_word_pe #(.W(W), .MAX_WORDS(MW)) i_mont_word_pe (
    .clk_i, .rst_ni, .start_i, .nbits_i, .gf_mode_i,
    .x_addr_o, .x_word_i, .rd_addr_o, .y_word_i, .m_word_i, .z_word_i,
    .z_we_o, .z_waddr_o, .z_wdata_o, .busy_o, .done_o
  );

  logic [W-1:0] x_mem [16];
  logic [W-1:0] y_mem [16];
  logic [W-1:0] m_mem [16];
  logic [W-1:0] z_mem [16];

  always @(posedge clk_i) begin
    x_word_i <= x_mem[x_addr_o];
    y_word_i <= y_mem[rd_addr_o];
    m_word_i <= m_mem[rd_addr_o];
    z_word_i <= z_mem[rd_addr_o];
    if (z_we_o) z_mem[z_waddr_o] <= z_wdata_o;
  end

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: Z after each outer step
  logic [127:0] ref_hist [0:64];
  int cur_e, cur_n, wr_cnt;
  bit mon_en = 1'b0;

  task automatic ref_build(int n, logic [127:0] x, logic [127:0] y, logic [127:0] m, bit gf);
    logic [127:0] z;
    z = '0;
    ref_hist[0] = z;
    for (int s = 0; s < n; s++) begin
      if (gf) begin
        if (x[s]) z = z ^ y;
        if (z[0]) z = z ^ m;
      end else begin
        if (x[s]) z = z + y;
        if (z[0]) z = z + m;
      end
      z = z >> 1;
      ref_hist[s+1] = z;
    end
  endtask

  function automatic logic [255:0] clmul(logic [255:0] a, logic [255:0] b);
    logic [255:0] r;
    r = '0;
    for (int k = 0; k < 128; k++) if (b[k]) r = r ^ (a << k);
    return r;
  endfunction

  function automatic logic [255:0] pmod(logic [255:0] a, logic [255:0] m, int deg);
    for (int k = 255; k >= deg; k--) if (a[k]) a = a ^ (m << (k - deg));
    return a;
  endfunction

  // every store write compared with the model (R4, R5), none allowed while idle (R1)
  always @(negedge clk_i) begin
    if (rst_ni && z_we_o) begin
      if (mon_en) begin
        int k, it;
        logic [W-1:0] exp_w;
        k  = wr_cnt % (cur_e + 1);
        it = wr_cnt / (cur_e + 1);
        if (it >= cur_n) begin
          chk(1'b0, "R5 extra write", 256'(wr_cnt), 256'(cur_n*(cur_e+1)));
        end else begin
          exp_w = ref_hist[it+1][k*W +: W];
          chk(z_waddr_o == AW'(k) && z_wdata_o == exp_w, "R4 R5 written word",
              {z_waddr_o, z_wdata_o}, {AW'(k), exp_w});
        end
        wr_cnt++;
      end else begin
        chk(1'b0, "R1 write while idle", 256'(z_waddr_o), 256'(0));
      end
    end
  end

  task automatic run_case(string req, int n, logic [127:0] x, logic [127:0] y,
                          logic [127:0] m, bit gf, int mid_start);
    int e, cnt;
    bit busy_gap;
    logic [255:0] zfin;
    e = (n + W - 1) / W;
    for (int w = 0; w < 16; w++) begin
      x_mem[w] = x[w*W +: W];
      y_mem[w] = (w < e) ? y[w*W +: W] : 8'hC3;  // R8 filler
      m_mem[w] = (w < e) ? m[w*W +: W] : 8'h5A;
      z_mem[w] = 8'hA5;                            // R7 filler
    end
    ref_build(n, x, y, m, gf);
    cur_e = e; cur_n = n; wr_cnt = 0; mon_en = 1'b1;
    @(negedge clk_i);
    nbits_i = NBW'(n); gf_mode_i = gf; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    cnt = 0; busy_gap = 1'b0;
    while (!done_o && cnt < 20000) begin
      @(posedge clk_i);
      cnt++;
      @(negedge clk_i);
      if (!busy_o) busy_gap = 1'b1;
      if (cnt == mid_start) begin
        start_i = 1'b1; nbits_i = NBW'(40); gf_mode_i = ~gf;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk(cnt == n*(e+1)+2, {req, " R2 latency"}, 256'(cnt), 256'(n*(e+1)+2));
    chk(!busy_gap, {req, " R2 busy held"}, 256'(busy_gap), 256'(0));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!done_o && !busy_o, {req, " R2 single pulse"}, {done_o, busy_o}, 256'(0));
    mon_en = 1'b0;
    chk(wr_cnt == n*(e+1), {req, " R5 write count"}, 256'(wr_cnt), 256'(n*(e+1)));
    zfin = '0;
    for (int w = 0; w <= e; w++) zfin[w*W +: W] = z_mem[w];
    chk(zfin == 256'(ref_hist[n]), {req, " final Z"}, zfin, 256'(ref_hist[n]));
    if (!gf) begin
      chk(zfin < 2 * 256'(m), {req, " R3 bound"}, zfin, 2 * 256'(m));
      chk(((zfin << n) % 256'(m)) == ((256'(x) * 256'(y)) % 256'(m)), {req, " R3 congruence"},
          (zfin << n) % 256'(m), (256'(x) * 256'(y)) % 256'(m));
    end else begin
      chk(pmod(zfin << n, 256'(m), n) == pmod(clmul(256'(x), 256'(y)), 256'(m), n),
          {req, " R6 congruence"}, pmod(zfin << n, 256'(m), n),
          pmod(clmul(256'(x), 256'(y)), 256'(m), n));
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int w = 0; w < 16; w++) begin
      x_mem[w] = '0; y_mem[w] = '0; m_mem[w] = '0; z_mem[w] = '0;
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !z_we_o, "R1 reset state", {busy_o, done_o, z_we_o}, 256'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !done_o && !z_we_o, "R1 idle after reset", {busy_o, done_o, z_we_o}, 256'(0));

    run_case("R4 R7 R8 n20",  20, 128'hABCDE, 128'h5B3F1, 128'hC3A57, 1'b0, -1);
    run_case("R3 n64",        64, 128'hFFFF_FFFF_FFFF_FFFF, 128'hF123_4567_89AB_CDEE,
             128'hF123_4567_89AB_CDEF, 1'b0, -1);
    run_case("R2 min n9",      9, 128'h1FF, 128'h1A2, 128'h1F7, 1'b0, -1);
    run_case("R8 n16",        16, 128'h8001, 128'h7FFF, 128'hE9B1, 1'b0, -1);
    run_case("R6 gf n13",     13, 128'h1ACE, 128'h0F3D, 128'h201B, 1'b1, -1);
    run_case("R9 n33",        33, 128'h1_2345_6789, 128'h0_DEAD_BEEF, 128'h1_9E37_79B9, 1'b0, 10);
    run_case("R6 gf n30",     30, 128'h2BAD_F00D, 128'h1234_5678, 128'h4000_0053, 1'b1, -1);

    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !z_we_o, "R1 idle at end", {busy_o, done_o, z_we_o}, 256'(0));
    summary();
  end
endmodule